// File: doc/BRIEF.md
# Exact Divide-by-2^n Scaler for a Three-Channel Residue Number

This block takes an integer held as three residues, modulo 2^n−1, modulo 2^n and modulo 2^n+1, and returns the floor of that integer divided by 2^n. It produces the result in two forms at the same time. One form is the three residues of the quotient. The other is the quotient as an ordinary 2n-bit binary word. A downstream stage can therefore keep working in the residue domain, or take the binary value without a separate reverse converter.

Each channel uses adders only, with no lookup tables. The first residue comes from one end-around-carry adder of width n. The binary quotient comes from a 2n-bit carry-save reduction with end-around carry, followed by a modulo 2^{2n}−1 adder. The middle residue is simply the low n bits of that binary quotient. The last residue comes from a carry-save stage whose top carry is inverted and wrapped to bit 0, followed by a diminished-one adder modulo 2^n+1. The offset that the diminished-one form needs is built into a constant addend.

The residue arithmetic is combinational. A parameter adds one output register stage, which is on by default.

Top module: `rns_scaler_exact`

## Requirements
- R1: `out_lo` equals floor(X/2^N) mod (2^N−1), where X is the integer the inputs encode. It never takes the value 2^N−1.
- R2: `out_mid` equals floor(X/2^N) mod 2^N.
- R3: `out_hi` equals floor(X/2^N) mod (2^N+1). It never exceeds 2^N.
- R4: `out_bin` equals floor(X/2^N) exactly, for every X from 0 to 2^N·(2^{2N}−1)−1. It is never all ones.
- R5: `out_mid` always equals the N least significant bits of `out_bin`.
- R6: With N=8, inputs (80, 132, 29) give outputs (203, 153, 103) and `out_bin` = 12953.
- R7: Every X below 2^N gives zero on all four outputs, including `out_hi`, whose zero has no diminished-one code.
- R8: An input `res_hi` of exactly 2^N (bit N set, low bits zero) is scaled correctly.
- R9: With REG_OUT=1, the outputs change one clock edge after the inputs do, and stay zero while `rst_n` is low. With REG_OUT=0, the outputs follow the inputs without a clock.
- R10: `out_bin` reduced mod 2^N−1 equals `out_lo`, and `out_bin` reduced mod 2^N+1 equals `out_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| res_lo | input | N | Input residue mod 2^N−1 |
| res_mid | input | N | Input residue mod 2^N |
| res_hi | input | N+1 | Input residue mod 2^N+1 |
| out_lo | output | N | Quotient residue mod 2^N−1 |
| out_mid | output | N | Quotient residue mod 2^N |
| out_hi | output | N+1 | Quotient residue mod 2^N+1 |
| out_bin | output | 2N | Quotient as a binary word |

## Verification
The hardest cases to reach from the ports are the corner codes of the 2^N+1 channel. One is the input residue 2^N, the only value that sets bit N. The other is a quotient whose residue is zero, where the diminished-one adder has to report zero through its all-ones detection. Random integers rarely produce either, so the bench builds inputs of the form 257·k+256 to force the top residue. It sweeps integers below 2^N to force all-zero quotients. A second, combinational instance with N=4 is driven over its entire 4080-value range, so every carry and wrap path at that width is exercised.

// File: rtl/rns_scale_pkg.sv
`timescale 1ns/1ps
package rns_scale_pkg;
  // How the carry out of the top bit of a carry-save row re-enters bit 0
  typedef enum logic {
    WRAP_PLAIN  = 1'b0,  // weight 2^W == +1  (modulus 2^W-1)
    WRAP_INVERT = 1'b1   // weight 2^W == -1  (modulus 2^W+1, offset -1 per row)
  } wrap_kind_e;
endpackage

// File: rtl/rns_csa_ring.sv
`timescale 1ns/1ps
module rns_csa_ring #(
  parameter int W = 8,
  parameter rns_scale_pkg::wrap_kind_e KIND = rns_scale_pkg::WRAP_PLAIN
) (
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  output logic [W-1:0] row_sum,
  output logic [W-1:0] row_carry,
  output logic         wrap_out
);
  logic [W-1:0] maj;

  always_comb begin
    row_sum = in_a ^ in_b ^ in_c;
    maj     = (in_a & in_b) | (in_a & in_c) | (in_b & in_c);
  end

  assign wrap_out = maj[W-1];

  generate
    if (KIND == rns_scale_pkg::WRAP_PLAIN) begin : g_plain
      assign row_carry = {maj[W-2:0], maj[W-1]};
    end else begin : g_invert
      assign row_carry = {maj[W-2:0], ~maj[W-1]};
    end
  endgenerate
endmodule

// File: rtl/rns_lo_chan.sv
`timescale 1ns/1ps
module rns_lo_chan #(
  parameter int N = 8
) (
  input  logic [N-1:0] x_lo,
  input  logic [N-1:0] x_mid,
  output logic [N-1:0] y_lo
);
  // Canonical sum mod 2^N-1: result in 0 .. 2^N-2
  function automatic logic [N-1:0] add_ones_ring(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [N:0] raw;
    logic [N:0] probe;
    raw   = {1'b0, a} + {1'b0, b};
    probe = raw + {{N{1'b0}}, 1'b1};
    return raw[N-1:0] + {{(N-1){1'b0}}, probe[N]};
  endfunction

  // quotient mod (2^N-1) = x_lo - x_mid, negation by one's complement
  logic [N-1:0] neg_mid;
  assign neg_mid = ~x_mid;
  assign y_lo    = add_ones_ring(x_lo, neg_mid);

  always_comb begin
    if (!$isunknown(y_lo)) begin
      // R1
      lo_range_chk: assert (y_lo != {N{1'b1}})
        else $error("lo channel produced non-canonical all-ones");
    end
  end
endmodule

// File: rtl/rns_mid_chan.sv
`timescale 1ns/1ps
module rns_mid_chan #(
  parameter int N = 8
) (
  input  logic [N-1:0]   x_lo,
  input  logic [N-1:0]   x_mid,
  input  logic [N:0]     x_hi,
  output logic [2*N-1:0] y_bin
);
  localparam int W   = 2 * N;
  localparam int ROT = N - 1;

  function automatic logic [W-1:0] rotl(input logic [W-1:0] v);
    return (v << ROT) | (v >> (W - ROT));
  endfunction

  // Canonical sum mod 2^W-1
  function automatic logic [W-1:0] add_ring(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] raw;
    logic [W:0] probe;
    raw   = {1'b0, a} + {1'b0, b};
    probe = raw + {{W{1'b0}}, 1'b1};
    return raw[W-1:0] + {{(W-1){1'b0}}, probe[W]};
  endfunction

  // Quotient mod (2^2N-1):
  //   x_lo*2^(N-1)*(2^N+1) - x_mid*2^N + x_hi*2^(N-1)*(1-2^N)
  logic [W-1:0] vec_lo, vec_mid, vec_hi_pos, vec_hi_neg;
  logic [W-1:0] hi_shift;

  always_comb begin
    vec_lo     = rotl({x_lo, x_lo});
    vec_mid    = {~x_mid, {N{1'b1}}};
    vec_hi_pos = rotl({{(N-1){1'b0}}, x_hi});
    hi_shift   = {x_hi[N-1:0], {(N-1){1'b0}}, x_hi[N]};
    vec_hi_neg = rotl(~hi_shift);
  end

  logic [W-1:0] s1, c1, s2, c2;
  logic         w1, w2;

  rns_csa_ring #(.W(W), .KIND(rns_scale_pkg::WRAP_PLAIN)) u_row1 (
    .in_a(vec_lo), .in_b(vec_mid), .in_c(vec_hi_pos),
    .row_sum(s1), .row_carry(c1), .wrap_out(w1)
  );

  rns_csa_ring #(.W(W), .KIND(rns_scale_pkg::WRAP_PLAIN)) u_row2 (
    .in_a(s1), .in_b(c1), .in_c(vec_hi_neg),
    .row_sum(s2), .row_carry(c2), .wrap_out(w2)
  );

  assign y_bin = add_ring(s2, c2);

  always_comb begin
    if (!$isunknown({y_bin, w1, w2})) begin
      // R4
      bin_span_chk: assert (y_bin != {W{1'b1}})
        else $error("binary quotient hit the excluded all-ones code");
    end
  end
endmodule

// File: rtl/rns_hi_chan.sv
`timescale 1ns/1ps
module rns_hi_chan #(
  parameter int N = 8
) (
  input  logic [N-1:0] x_mid,
  input  logic [N:0]   x_hi,
  output logic [N:0]   y_hi
);
  localparam logic [N:0] TOP = (N+1)'(1) << N;

  // Operands are diminished-one codes (value - 1); returns the plain sum mod 2^N+1
  function automatic logic [N:0] add_dim1(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [N:0] t;
    t = {1'b0, a} + {1'b0, b};
    if (t[N])                 return {1'b0, t[N-1:0]} + (N+1)'(1);
    else if (&t[N-1:0])       return '0;
    else                      return t + (N+1)'(2);
  endfunction

  // quotient mod (2^N+1) = x_mid - x_hi.
  // Addends: x_mid, ~low(x_hi), {0..,top(x_hi)}, all-ones (offset constant).
  logic [N-1:0] op_a, op_b, op_c, op_k;
  always_comb begin
    op_a = x_mid;
    op_b = ~x_hi[N-1:0];
    op_c = {{(N-1){1'b0}}, x_hi[N]};
    op_k = {N{1'b1}};
  end

  logic [N-1:0] s1, c1, s2, c2;
  logic         w1, w2;

  rns_csa_ring #(.W(N), .KIND(rns_scale_pkg::WRAP_INVERT)) u_row1 (
    .in_a(op_a), .in_b(op_b), .in_c(op_k),
    .row_sum(s1), .row_carry(c1), .wrap_out(w1)
  );

  rns_csa_ring #(.W(N), .KIND(rns_scale_pkg::WRAP_INVERT)) u_row2 (
    .in_a(s1), .in_b(c1), .in_c(op_c),
    .row_sum(s2), .row_carry(c2), .wrap_out(w2)
  );

  assign y_hi = add_dim1(s2, c2);

  always_comb begin
    if (!$isunknown({y_hi, w1, w2})) begin
      // R3
      hi_range_chk: assert (y_hi <= TOP)
        else $error("hi channel residue above 2^N");
    end
  end
endmodule

// File: rtl/rns_scaler_exact.sv
`timescale 1ns/1ps
module rns_scaler_exact #(
  parameter int N       = 8,
  parameter int REG_OUT = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   res_lo,
  input  logic [N-1:0]   res_mid,
  input  logic [N:0]     res_hi,
  output logic [N-1:0]   out_lo,
  output logic [N-1:0]   out_mid,
  output logic [N:0]     out_hi,
  output logic [2*N-1:0] out_bin
);
  localparam int W = 2 * N;
  localparam logic [W-1:0] M_LO = W'((64'd1 << N) - 64'd1);
  localparam logic [W-1:0] M_HI = W'((64'd1 << N) + 64'd1);

  logic [N-1:0] lo_c;
  logic [N:0]   hi_c;
  logic [W-1:0] bin_c;

  rns_lo_chan  #(.N(N)) u_lo  (.x_lo(res_lo), .x_mid(res_mid), .y_lo(lo_c));
  rns_mid_chan #(.N(N)) u_mid (.x_lo(res_lo), .x_mid(res_mid), .x_hi(res_hi), .y_bin(bin_c));
  rns_hi_chan  #(.N(N)) u_hi  (.x_mid(res_mid), .x_hi(res_hi), .y_hi(hi_c));

  generate
    if (REG_OUT != 0) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_lo  <= '0;
          out_mid <= '0;
          out_hi  <= '0;
          out_bin <= '0;
        end else begin
          out_lo  <= lo_c;
          out_mid <= bin_c[N-1:0];
          out_hi  <= hi_c;
          out_bin <= bin_c;
        end
      end
    end else begin : g_comb
      assign out_lo  = lo_c;
      assign out_mid = bin_c[N-1:0];
      assign out_hi  = hi_c;
      assign out_bin = bin_c;
    end
  endgenerate

  // Channels are built independently; their results must agree
  always_comb begin
    if (!$isunknown({bin_c, lo_c, hi_c})) begin
      // R10
      lo_cross_chk: assert ((bin_c % M_LO) == {{N{1'b0}}, lo_c})
        else $error("lo residue disagrees with binary quotient");
      // R10
      hi_cross_chk: assert ((bin_c % M_HI) == {{(N-1){1'b0}}, hi_c})
        else $error("hi residue disagrees with binary quotient");
    end
  end
endmodule

// File: tb/sim_rns_scaler_exact.sv
`timescale 1ns/1ps
module sim_rns_scaler_exact;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // N = 8, registered
  logic [7:0]  a8 = '0, b8 = '0;
  logic [8:0]  c8 = '0;
  logic [7:0]  lo8, mid8;
  logic [8:0]  hi8;
  logic [15:0] bin8;

  rns_scaler_exact #(.N(8), .REG_OUT(1)) u0 (
    .clk(clk), .rst_n(rst_n), .res_lo(a8), .res_mid(b8), .res_hi(c8),
    .out_lo(lo8), .out_mid(mid8), .out_hi(hi8), .out_bin(bin8)
  );

  // N = 4, combinational
  logic [3:0] a4 = '0, b4 = '0;
  logic [4:0] c4 = '0;
  logic [3:0] lo4, mid4;
  logic [4:0] hi4;
  logic [7:0] bin4;

  rns_scaler_exact #(.N(4), .REG_OUT(0)) u1 (
    .clk(clk), .rst_n(rst_n), .res_lo(a4), .res_mid(b4), .res_hi(c4),
    .out_lo(lo4), .out_mid(mid4), .out_hi(hi4), .out_bin(bin4)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive X into u0 and check after the capturing edge
  task automatic run8(input longint x, input string tag);
    longint q;
    q = x >> 8;
    @(negedge clk);
    a8 = 8'(x % 255); b8 = 8'(x % 256); c8 = 9'(x % 257);
    @(posedge clk); #1;
    check({tag, " R1 lo"},  lo8,  q % 255);
    check({tag, " R2 mid"}, mid8, q % 256);
    check({tag, " R3 hi"},  hi8,  q % 257);
    check({tag, " R4 bin"}, bin8, q);
    check({tag, " R5 slice"}, mid8, bin8 % 256);
  endtask

  task automatic test_reset;
    @(negedge clk);
    a8 = 8'd80; b8 = 8'd132; c8 = 9'd29;
    @(posedge clk); #1;
    check("R9 reset lo", lo8, 0);
    check("R9 reset hi", hi8, 0);
    check("R9 reset bin", bin8, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic test_example;
    @(negedge clk);
    a8 = 8'd80; b8 = 8'd132; c8 = 9'd29;
    @(posedge clk); #1;
    check("R6 lo", lo8, 203);
    check("R6 mid", mid8, 153);
    check("R6 hi", hi8, 103);
    check("R6 bin", bin8, 12953);
  endtask

  task automatic test_latency;
    // previous result must hold until the next edge
    @(negedge clk);
    a8 = 8'(1000000 % 255); b8 = 8'(1000000 % 256); c8 = 9'(1000000 % 257);
    #1;
    check("R9 hold bin", bin8, 12953);
    @(posedge clk); #1;
    check("R9 update bin", bin8, 1000000 >> 8);
  endtask

  task automatic test_small;
    for (int x = 0; x < 256; x += 17) run8(x, "R7 small");
    run8(255, "R7 small");
    check("R7 zero hi", hi8, 0);
  endtask

  task automatic test_top_code;
    for (int k = 0; k < 40; k++) run8(longint'(257) * (k * 1543 + 11) + 256, "R8 top");
  endtask

  task automatic test_edges;
    run8(longint'(255) * 256 * 257 - 1, "R4 max");
    run8(256, "R4 one");
    run8(longint'(255) * 256 * 257 - 256, "R4 maxq");
  endtask

  task automatic test_random8;
    for (int i = 0; i < 2000; i++) run8(longint'($urandom % 32'd16776960), "rand8");
  endtask

  task automatic test_full4;
    for (int x = 0; x < 4080; x++) begin
      int q;
      q = x >> 4;
      a4 = 4'(x % 15); b4 = 4'(x % 16); c4 = 5'(x % 17);
      #1;
      check("R1 n4 lo", lo4, q % 15);
      check("R2 n4 mid", mid4, q % 16);
      check("R3 n4 hi", hi4, q % 17);
      check("R4 n4 bin", bin4, q);
      if (x == 4079) check("R9 comb", bin4, 254);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_example();
    test_latency();
    test_small();
    test_top_code();
    test_edges();
    test_random8();
    test_full4();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule